// File: doc/BRIEF.md
# Two-Stage IIR Level Detector

This block forms the level-sensing front end of a dynamic range compressor. Each incoming signed audio sample comes with a valid strobe. The sample passes through a programmable first-order high-pass section. It then passes through a programmable first-order low-pass section. The high-pass result leaves the block as a filtered sample stream for the channel path. The magnitude of the low-pass result leaves as a slowly varying energy estimate for the compressor's gain logic.

Both sections use the same recursion, `y[n] = (N0*x[n] + N1*x[n-1] + D1*y[n-1]) >>> 15`, with an arithmetic (floor) shift. Each section has its own three 16-bit two's-complement coefficients, loaded through a single-cycle write strobe. Each section result is clamped to the 16-bit signed range before it is stored or passed on. The reset values of the coefficients give a high-pass corner near 0.00166·fs and a low-pass corner near 0.00033·fs.

Top module: `iir_level_detector`

## Requirements
- R1: On a cycle with `in_valid` high, the high-pass output `hp_sample` (with `hp_valid` high for one cycle) appears one clock later and equals sat16((HN0*x + HN1*xh1 + HD1*yh1) >>> 15). Here xh1 and yh1 are the previous accepted input and the previous high-pass output.
- R2: A section result outside [-32768, 32767] is clamped to the nearer limit, and that clamped value is the one kept as the section's delay state.
- R3: The low-pass section takes the clamped high-pass output as its input and applies the same recursion with LN0, LN1 and LD1.
- R4: `energy` equals the absolute value of the low-pass output and is presented with `energy_valid` high for one cycle, three clocks after the accepted input.
- R5: A low-pass output of -32768 gives an `energy` of 32767.
- R6: Cycles with `in_valid` low leave both delay lines and both outputs unchanged, and produce no valid pulse.
- R7: A write with `cfg_we` high stores `cfg_data` into the selected coefficient. The selection codes are 0=HN0, 1=HN1, 2=HD1, 3=LN0, 4=LN1 and 5=LD1. The new value is used from the next accepted sample onward.
- R8: Writes with `cfg_addr` 6 or 7 change no coefficient.
- R9: A synchronous reset clears both delay lines and all outputs. It also reloads the coefficients with HN0=32598, HN1=-32598, HD1=32428, LN0=34, LN1=34 and LD1=32700.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Signed input sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 3 | Coefficient select |
| cfg_data | input | 16 | Coefficient value, two's complement |
| hp_valid | output | 1 | High-pass output strobe |
| hp_sample | output | 16 | Signed high-pass output |
| energy_valid | output | 1 | Energy estimate strobe |
| energy | output | 16 | Magnitude of the low-pass output |

## Verification
The bench drives both sections into positive and negative overflow.
- A design that wrapped instead of clamping would show a sign flip at the outputs.
- A design that stored the unclamped value as its delay state would show the error in the next output.

It forces a low-pass output of -32768. A plain negation would return a negative energy.

It writes to the unused selection codes and then probes with a sample. A design that aliased those codes onto a real coefficient would make the outputs drift from the reference model.

Idle cycles sit between samples, so any state that advances without a valid input shows up as a wrong next result.

// File: rtl/iir_det_pkg.sv
package iir_det_pkg;
  localparam int COEF_W = 16;

  typedef struct packed {
    logic signed [COEF_W-1:0] n0;
    logic signed [COEF_W-1:0] n1;
    logic signed [COEF_W-1:0] d1;
  } sect_coef_t;

  typedef enum logic [2:0] {
    SEL_HN0 = 3'd0,
    SEL_HN1 = 3'd1,
    SEL_HD1 = 3'd2,
    SEL_LN0 = 3'd3,
    SEL_LN1 = 3'd4,
    SEL_LD1 = 3'd5
  } coef_sel_e;
endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
  import iir_det_pkg::*;
#(
  parameter sect_coef_t HP_INIT = '0,
  parameter sect_coef_t LP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [COEF_W-1:0] wr_data,
  output sect_coef_t        hp_coef,
  output sect_coef_t        lp_coef
);
  sect_coef_t hp_q, lp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_q <= HP_INIT;
      lp_q <= LP_INIT;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_HN0: hp_q.n0 <= wr_data;
        SEL_HN1: hp_q.n1 <= wr_data;
        SEL_HD1: hp_q.d1 <= wr_data;
        SEL_LN0: lp_q.n0 <= wr_data;
        SEL_LN1: lp_q.n1 <= wr_data;
        SEL_LD1: lp_q.d1 <= wr_data;
        default: ;
      endcase
    end
  end

  assign hp_coef = hp_q;
  assign lp_coef = lp_q;

  AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel > 3'd5) |=> ($stable(hp_q) && $stable(lp_q))); // R8
endmodule

// File: rtl/iir_section.sv
module iir_section
  import iir_det_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  sect_coef_t               coef,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  localparam int ACC_W = DATA_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(2 ** (DATA_W - 1));

  logic signed [DATA_W-1:0] x_prev;
  logic signed [ACC_W-1:0]  acc, scaled;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    acc = ACC_W'(coef.n0) * ACC_W'(in_sample)
        + ACC_W'(coef.n1) * ACC_W'(x_prev)
        + ACC_W'(coef.d1) * ACC_W'(out_sample);
    scaled = acc >>> FRAC;
    if (scaled > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
    else                      clamped = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev     <= '0;
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x_prev     <= in_sample;
        out_sample <= clamped;
      end
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(x_prev) && $stable(out_sample))); // R6
  AST_STROBE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
endmodule

// File: rtl/iir_mag_stage.sv
module iir_mag_stage #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic        [DATA_W-1:0] out_mag
);
  localparam logic [DATA_W-1:0] NEG_FULL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_FULL = {1'b0, {(DATA_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (in_sample == NEG_FULL)  out_mag <= POS_FULL;
        else if (in_sample[DATA_W-1]) out_mag <= -in_sample;
        else                          out_mag <= in_sample;
      end
    end
  end

  AST_MAG_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_mag[DATA_W-1]); // R5
endmodule

// File: rtl/iir_level_detector.sv
module iir_level_detector
  import iir_det_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC   = 15,
  parameter logic signed [COEF_W-1:0] HP_N0 = 16'sd32598,
  parameter logic signed [COEF_W-1:0] HP_N1 = -16'sd32598,
  parameter logic signed [COEF_W-1:0] HP_D1 = 16'sd32428,
  parameter logic signed [COEF_W-1:0] LP_N0 = 16'sd34,
  parameter logic signed [COEF_W-1:0] LP_N1 = 16'sd34,
  parameter logic signed [COEF_W-1:0] LP_D1 = 16'sd32700
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [COEF_W-1:0]        cfg_data,
  output logic                     hp_valid,
  output logic signed [DATA_W-1:0] hp_sample,
  output logic                     energy_valid,
  output logic [DATA_W-1:0]        energy
);
  localparam sect_coef_t HP_INIT = '{n0: HP_N0, n1: HP_N1, d1: HP_D1};
  localparam sect_coef_t LP_INIT = '{n0: LP_N0, n1: LP_N1, d1: LP_D1};

  sect_coef_t               hp_coef, lp_coef;
  logic                     lp_valid;
  logic signed [DATA_W-1:0] lp_sample;

  iir_coef_bank #(.HP_INIT(HP_INIT), .LP_INIT(LP_INIT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_addr),
    .wr_data(cfg_data), .hp_coef(hp_coef), .lp_coef(lp_coef)
  );

  iir_section #(.DATA_W(DATA_W), .FRAC(FRAC)) u_hp (
    .clk(clk), .rst(rst), .coef(hp_coef), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(hp_valid), .out_sample(hp_sample)
  );

  iir_section #(.DATA_W(DATA_W), .FRAC(FRAC)) u_lp (
    .clk(clk), .rst(rst), .coef(lp_coef), .in_valid(hp_valid),
    .in_sample(hp_sample), .out_valid(lp_valid), .out_sample(lp_sample)
  );

  iir_mag_stage #(.DATA_W(DATA_W)) u_mag (
    .clk(clk), .rst(rst), .in_valid(lp_valid), .in_sample(lp_sample),
    .out_valid(energy_valid), .out_mag(energy)
  );

  AST_NO_SPURIOUS_HP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !hp_valid); // R6
  AST_ENERGY_FOLLOWS_LP: assert property (@(posedge clk) disable iff (rst)
    lp_valid |=> energy_valid); // R4
endmodule

// File: tb/test_iir_level_detector.sv
`timescale 1ns/1ps
module test_iir_level_detector;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic signed [15:0] in_sample;
  logic cfg_we;
  logic [2:0] cfg_addr;
  logic [15:0] cfg_data;
  logic hp_valid;
  logic signed [15:0] hp_sample;
  logic energy_valid;
  logic [15:0] energy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iir_level_detector i_iir_level_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hp_valid(hp_valid), .hp_sample(hp_sample),
    .energy_valid(energy_valid), .energy(energy)
  );

  // reference model state
  int c[6];
  int hx1, hy1, lx1, ly1;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int step(int n0, int n1, int d1, int x, int x1, int y1);
    longint acc;
    acc = longint'(n0) * x + longint'(n1) * x1 + longint'(d1) * y1;
    return sat16(acc >>> 15);
  endfunction

  function automatic int mag(int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    c[0] = 32598; c[1] = -32598; c[2] = 32428;
    c[3] = 34;    c[4] = 34;     c[5] = 32700;
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sample = '0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(hp_valid == 1'b0 && hp_sample == 16'sd0, "R9 hp after reset", int'(hp_sample), 0);
    chk(energy_valid == 1'b0 && energy == 16'd0, "R9 energy after reset", int'(energy), 0);
  endtask

  task automatic wr(input int sel, input int val);
    cfg_we = 1'b1; cfg_addr = 3'(sel); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 6) c[sel] = int'($signed(16'(val)));
  endtask

  // One sample with idle gaps; checks hp after 1 clock and energy after 3.
  task automatic push(input int x, input string req);
    int hexp, lexp, eexp;
    hexp = step(c[0], c[1], c[2], x, hx1, hy1);
    hx1 = x; hy1 = hexp;
    lexp = step(c[3], c[4], c[5], hexp, lx1, ly1);
    lx1 = hexp; ly1 = lexp;
    eexp = mag(lexp);
    in_valid = 1'b1; in_sample = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk(hp_valid === 1'b1 && int'(hp_sample) == hexp, {req, " R1 hp"}, int'(hp_sample), hexp);
    @(negedge clk);
    chk(hp_valid === 1'b0 && int'(hp_sample) == hexp, {req, " R6 hp idle"}, int'(hp_sample), hexp);
    @(negedge clk);
    chk(energy_valid === 1'b1 && int'(energy) == eexp, {req, " R3 R4 energy"}, int'(energy), eexp);
    @(negedge clk);
    chk(energy_valid === 1'b0 && int'(energy) == eexp, {req, " R6 energy idle"}, int'(energy), eexp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    do_reset();

    // R9 default coefficients: impulse and a step
    push(20000, "R9 default impulse");
    push(0, "R9 default tail");
    push(-12000, "R9 default neg");
    push(-12000, "R9 default hold");

    // R2 positive overflow in high-pass, fed to low-pass pass-through-ish
    wr(0, 32767); wr(1, 32767); wr(2, 0);
    wr(3, 32767); wr(4, 32767); wr(5, 0);
    push(32767, "R2 pos first");
    push(32767, "R2 pos sat");
    chk(hp_sample == 16'sd32767, "R2 hp clamp high", int'(hp_sample), 32767);
    // R5 negative overflow drives low-pass to -32768
    push(-32768, "R5 neg first");
    push(-32768, "R5 neg sat");
    chk(hp_sample == -16'sd32768, "R2 hp clamp low", int'(hp_sample), -32768);
    chk(energy == 16'd32767, "R5 abs of most negative", int'(energy), 32767);

    // R7 each coefficient select takes effect on the next sample
    wr(0, 16384); wr(1, 0); wr(2, 0); wr(3, 32767); wr(4, 0); wr(5, 0);
    push(1000, "R7 hn0 half");
    chk(hp_sample == 16'sd500, "R7 hn0 half gain", int'(hp_sample), 500);
    wr(1, 16384);
    push(1000, "R7 hn1");
    chk(hp_sample == 16'sd1000, "R7 hn1 adds prev", int'(hp_sample), 1000);
    wr(2, -8192);
    push(0, "R7 hd1");
    wr(4, 8192); wr(5, 4096);
    push(-3000, "R7 ln1 ld1");

    // R8 unused selects leave every coefficient untouched
    wr(6, 16'h7FFF); wr(7, 16'h8000);
    push(2500, "R8 after unused writes");
    push(-700, "R8 second sample");

    // R6 long idle stretch keeps state
    repeat (10) @(negedge clk);
    chk(hp_valid == 1'b0 && energy_valid == 1'b0, "R6 no pulse idle", int'(hp_valid), 0);
    push(0, "R6 after idle");

    // random coefficient sets and samples
    for (int blk = 0; blk < 8; blk++) begin
      for (int k = 0; k < 6; k++) wr(k, int'($urandom_range(0, 65535)) - 32768);
      for (int s = 0; s < 40; s++) begin
        int r;
        r = int'($urandom_range(0, 65535)) - 32768;
        if (s % 13 == 0) r = (s % 2 == 0) ? 32767 : -32768;
        push(r, "R1 random");
      end
    end

    // R9 reset mid-stream restores defaults and clears delay lines
    do_reset();
    push(15000, "R9 post reset default");
    push(-15000, "R9 post reset second");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule